// File: doc/BRIEF.md
# Loader Packet Receiver

This block sits behind a UART receiver and turns a stream of bytes into loader commands. It looks for a two-byte start marker and then reads the packet. The packet carries a length byte, a command byte, a 32-bit address sent most-significant byte first, an optional payload and a closing checksum byte. It also checks that each address falls inside a configurable window. When the packet is complete, it sends a one-byte reply for the transmitter to send back to the host.

Write packets put their payload into memory while it arrives, one byte at a time, at addresses that count up. The reply comes only after the checksum byte. A run packet that is accepted raises a one-cycle run request, together with the start address, for the control logic above. An info packet that is accepted raises a one-cycle info request, and the parent then sends the identity response.

Top module: `ldr_pkt_rx`

## Requirements
- R1: A packet starts only after byte 0x07 is followed at once by byte 0x0E. Other bytes are ignored while the receiver hunts. A repeated 0x07 (07 07 0E) still starts a packet.
- R2: The byte after the start marker is the length L. L counts the command byte, the four address bytes and the payload bytes. The byte after those L bytes is the checksum. L = 255 carries a 250-byte payload.
- R3: The low 8 bits of the sum of the length byte, the L body bytes and the checksum byte must be zero. If they are not, the reply is NAK.
- R4: The four address bytes arrive most-significant byte first. The first address byte is bits 31:24.
- R5: For a write command ('W', 0x57), payload byte i goes out on the memory port at address start+i. It appears one cycle after the byte is taken, if that address lies in [win_lo, win_hi] inclusive. Writes are made whether or not the checksum later passes.
- R6: A write packet with any payload address outside the window gets a NAK. The bytes that fall outside the window are not written. A run packet whose address lies outside the window also gets a NAK.
- R7: One cycle after the checksum byte is taken, tx_valid pulses for one cycle. tx_data is 0x06 (ACK) for a good packet and 0x07 (NAK) otherwise. After reset no output is active.
- R8: An accepted run packet ('R', 0x52) pulses run_req in the same cycle as its ACK, with run_addr set to the packet address. An accepted info packet ('I', 0x49) pulses info_req in the same way. The address of an info packet is ignored, even when it lies outside the window.
- R9: A length below 5 or an unknown command byte gets a NAK after the checksum byte. Such a packet makes no memory write, no run request and no info request.
- R10: A byte that arrives with rx_err set is dropped and the packet being received is abandoned. A NAK follows in the next cycle, and the receiver goes back to hunting for the start marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | Framing or break error on this byte |
| win_lo | input | 32 | Lowest address of the allowed window |
| win_hi | input | 32 | Highest address of the allowed window |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | 32 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| tx_valid | output | 1 | Reply byte is valid |
| tx_data | output | 8 | Reply byte (0x06 or 0x07) |
| run_req | output | 1 | One-cycle run request |
| run_addr | output | 32 | Address for the run request |
| info_req | output | 1 | One-cycle info request |

## Verification
The hardest case to reach is a write whose payload runs across the top of the address window. Here the block must write the bytes that are still inside the window, drop the rest, and still answer with a NAK. Random start addresses alone seldom land within 250 bytes of win_hi. The stimulus therefore draws many write addresses from a band just below the top of the window, and adds a directed packet that straddles it. Packets are also sent with a corrupted checksum, a short length, an unknown command and an error byte in the middle of a packet, with random idle gaps between bytes.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  parameter int ADDR_W = 32;
  localparam int BYTE_W = 8;
  localparam int HDR_BYTES = 1 + ADDR_W / BYTE_W;
  localparam int CNT_W = BYTE_W;

  localparam logic [7:0] SYNC_A  = 8'h07;
  localparam logic [7:0] SYNC_B  = 8'h0E;
  localparam logic [7:0] OP_WR   = 8'h57;
  localparam logic [7:0] OP_RUN  = 8'h52;
  localparam logic [7:0] OP_INFO = 8'h49;
  localparam logic [7:0] RSP_ACK = 8'h06;
  localparam logic [7:0] RSP_NAK = 8'h07;

  typedef enum logic [2:0] {
    FR_HUNT0, FR_HUNT1, FR_LEN, FR_BODY, FR_CSUM
  } fr_state_e;

  function automatic logic [7:0] sum8(input logic [7:0] a, input logic [7:0] b);
    return a + b;
  endfunction

  function automatic logic in_win(input logic [ADDR_W-1:0] a,
                                  input logic [ADDR_W-1:0] lo,
                                  input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic op_known(input logic [7:0] op);
    return (op == OP_WR) || (op == OP_RUN) || (op == OP_INFO);
  endfunction
endpackage

// File: rtl/ldr_framer.sv
module ldr_framer
  import ldr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_err,
  output logic              pkt_start,
  output logic              pay_stb,
  output logic [7:0]        pay_byte,
  output logic              hdr_done,
  output logic [ADDR_W-1:0] hdr_addr,
  output logic [ADDR_W-1:0] addr_q,
  output logic [7:0]        cmd_q,
  output logic              end_stb,
  output logic              sum_ok,
  output logic              len_ok,
  output logic              abort_stb
);
  fr_state_e         st;
  logic [CNT_W-1:0]  len_q;
  logic [CNT_W-1:0]  cnt;
  logic [7:0]        sum_q;
  logic              take;
  logic              in_body;

  assign take      = rx_valid && !rx_err;
  assign abort_stb = rx_valid && rx_err;
  assign in_body   = (st == FR_BODY) && take;
  assign pkt_start = (st == FR_LEN) && take;
  assign pay_stb   = in_body && (cnt >= CNT_W'(HDR_BYTES));
  assign pay_byte  = rx_data;
  assign hdr_done  = in_body && (cnt == CNT_W'(HDR_BYTES - 1));
  assign hdr_addr  = {addr_q[ADDR_W-9:0], rx_data};
  assign end_stb   = (st == FR_CSUM) && take;
  assign sum_ok    = (sum8(sum_q, rx_data) == 8'h00);
  assign len_ok    = (len_q >= CNT_W'(HDR_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= FR_HUNT0;
      len_q  <= '0;
      cnt    <= '0;
      sum_q  <= '0;
      cmd_q  <= '0;
      addr_q <= '0;
    end else if (abort_stb) begin
      st <= FR_HUNT0;
    end else if (take) begin
      unique case (st)
        FR_HUNT0: if (rx_data == SYNC_A) st <= FR_HUNT1;
        FR_HUNT1: begin
          if (rx_data == SYNC_B)      st <= FR_LEN;
          else if (rx_data != SYNC_A) st <= FR_HUNT0;
        end
        FR_LEN: begin
          len_q <= rx_data;
          sum_q <= rx_data;
          cnt   <= '0;
          cmd_q <= '0;
          st    <= (rx_data == 8'd0) ? FR_CSUM : FR_BODY;
        end
        FR_BODY: begin
          sum_q <= sum8(sum_q, rx_data);
          cnt   <= cnt + CNT_W'(1);
          if (cnt == '0) cmd_q <= rx_data;
          else if (cnt < CNT_W'(HDR_BYTES)) addr_q <= hdr_addr;
          if (cnt + CNT_W'(1) == len_q) st <= FR_CSUM;
        end
        FR_CSUM: st <= FR_HUNT0;
        default: st <= FR_HUNT0;
      endcase
    end
  end

  // R1: the length state is entered only right after a 0x0E byte was taken
  a_r1_sync_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FR_LEN && $past(st) != FR_LEN) |->
      ($past(rx_valid) && $past(rx_data) == SYNC_B));

  // R2: body bytes never exceed the advertised length
  a_r2_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FR_BODY) |-> (cnt < len_q));
endmodule

// File: rtl/ldr_wr_path.sv
module ldr_wr_path
  import ldr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_start,
  input  logic              hdr_done,
  input  logic [ADDR_W-1:0] hdr_addr,
  input  logic [7:0]        cmd_q,
  input  logic              pay_stb,
  input  logic [7:0]        pay_byte,
  input  logic [ADDR_W-1:0] win_lo,
  input  logic [ADDR_W-1:0] win_hi,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              range_bad
);
  logic [ADDR_W-1:0] wptr;
  logic              is_wr;
  logic              hdr_chk;
  logic              ptr_ok;

  assign is_wr   = (cmd_q == OP_WR);
  assign hdr_chk = is_wr || (cmd_q == OP_RUN);
  assign ptr_ok  = in_win(wptr, win_lo, win_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr      <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      range_bad <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (pkt_start) range_bad <= 1'b0;
      if (hdr_done) begin
        wptr <= hdr_addr;
        if (hdr_chk && !in_win(hdr_addr, win_lo, win_hi)) range_bad <= 1'b1;
      end
      if (pay_stb) begin
        wptr <= wptr + ADDR_W'(1);
        if (is_wr && ptr_ok) begin
          mem_we    <= 1'b1;
          mem_addr  <= wptr;
          mem_wdata <= pay_byte;
        end
        if (is_wr && !ptr_ok) range_bad <= 1'b1;
      end
    end
  end

  // R5: back-to-back writes go to consecutive addresses
  a_r5_incr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  // R9: only a write command reaches the memory port
  a_r9_wr_only: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(cmd_q) == OP_WR));
endmodule

// File: rtl/ldr_reply.sv
module ldr_reply
  import ldr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              end_stb,
  input  logic              abort_stb,
  input  logic              sum_ok,
  input  logic              len_ok,
  input  logic              range_bad,
  input  logic [7:0]        cmd_q,
  input  logic [ADDR_W-1:0] addr_q,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              run_req,
  output logic [ADDR_W-1:0] run_addr,
  output logic              info_req
);
  logic pkt_good;

  assign pkt_good = sum_ok && len_ok && op_known(cmd_q) && !range_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      run_req  <= 1'b0;
      run_addr <= '0;
      info_req <= 1'b0;
    end else begin
      tx_valid <= 1'b0;
      run_req  <= 1'b0;
      info_req <= 1'b0;
      if (abort_stb) begin
        tx_valid <= 1'b1;
        tx_data  <= RSP_NAK;
      end else if (end_stb) begin
        tx_valid <= 1'b1;
        tx_data  <= pkt_good ? RSP_ACK : RSP_NAK;
        run_req  <= pkt_good && (cmd_q == OP_RUN);
        info_req <= pkt_good && (cmd_q == OP_INFO);
        if (pkt_good && cmd_q == OP_RUN) run_addr <= addr_q;
      end
    end
  end

  // R7: reply is always one of the two codes
  a_r7_code: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_data == RSP_ACK || tx_data == RSP_NAK));

  // R8: at most one upward request at a time
  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({run_req, info_req}));

  // R3: a failed sum yields a NAK and no request
  a_r3_bad_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (end_stb && !sum_ok) |=> (tx_valid && tx_data == RSP_NAK && !run_req && !info_req));

  // R9: a short length yields a NAK
  a_r9_short: assert property (@(posedge clk) disable iff (!rst_n)
    (end_stb && !len_ok) |=> (tx_data == RSP_NAK && !run_req && !info_req));
endmodule

// File: rtl/ldr_pkt_rx.sv
module ldr_pkt_rx
  import ldr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_err,
  input  logic [ADDR_W-1:0] win_lo,
  input  logic [ADDR_W-1:0] win_hi,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              run_req,
  output logic [ADDR_W-1:0] run_addr,
  output logic              info_req
);
  logic              pkt_start;
  logic              pay_stb;
  logic [7:0]        pay_byte;
  logic              hdr_done;
  logic [ADDR_W-1:0] hdr_addr;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        cmd_q;
  logic              end_stb;
  logic              sum_ok;
  logic              len_ok;
  logic              abort_stb;
  logic              range_bad;

  ldr_framer u_framer (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
    .pkt_start(pkt_start), .pay_stb(pay_stb), .pay_byte(pay_byte),
    .hdr_done(hdr_done), .hdr_addr(hdr_addr), .addr_q(addr_q), .cmd_q(cmd_q),
    .end_stb(end_stb), .sum_ok(sum_ok), .len_ok(len_ok), .abort_stb(abort_stb)
  );

  ldr_wr_path u_wr (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .hdr_done(hdr_done),
    .hdr_addr(hdr_addr), .cmd_q(cmd_q), .pay_stb(pay_stb), .pay_byte(pay_byte),
    .win_lo(win_lo), .win_hi(win_hi), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .range_bad(range_bad)
  );

  ldr_reply u_reply (
    .clk(clk), .rst_n(rst_n), .end_stb(end_stb), .abort_stb(abort_stb),
    .sum_ok(sum_ok), .len_ok(len_ok), .range_bad(range_bad), .cmd_q(cmd_q),
    .addr_q(addr_q), .tx_valid(tx_valid), .tx_data(tx_data), .run_req(run_req),
    .run_addr(run_addr), .info_req(info_req)
  );

  // R10: an error byte is answered with a NAK in the next cycle
  a_r10_err_nak: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_err) |=> (tx_valid && tx_data == RSP_NAK));

  // R7: a reply is never produced without an input byte in the prior cycle
  a_r7_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(rx_valid));
endmodule

// File: tb/sim_ldr_pkt_rx.sv
module sim_ldr_pkt_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_err = 1'b0;
  logic [31:0] win_lo = 32'h2000_0000;
  logic [31:0] win_hi = 32'h2000_0FFF;
  logic        mem_we, tx_valid, run_req, info_req;
  logic [31:0] mem_addr, run_addr;
  logic [7:0]  mem_wdata, tx_data;

  always #4 clk = ~clk;

  ldr_pkt_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
    .win_lo(win_lo), .win_hi(win_hi), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .tx_valid(tx_valid), .tx_data(tx_data), .run_req(run_req),
    .run_addr(run_addr), .info_req(info_req)
  );

  int checks = 0;
  int fails = 0;

  logic [31:0] wa [0:511];
  logic [7:0]  wd [0:511];
  int wn = 0, tx_n = 0, run_n = 0, info_n = 0;
  logic [7:0]  tx_last = 8'h00;
  logic [31:0] run_last = 32'h0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        wa[wn % 512] = mem_addr;
        wd[wn % 512] = mem_wdata;
        wn = wn + 1;
      end
      if (tx_valid) begin
        tx_n = tx_n + 1;
        tx_last = tx_data;
      end
      if (run_req) begin
        run_n = run_n + 1;
        run_last = run_addr;
      end
      if (info_req) info_n = info_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit inw(input logic [31:0] a);
    return (a >= win_lo) && (a <= win_hi);
  endfunction

  task automatic send_byte(input logic [7:0] b, input bit err);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    rx_err   = err;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_err   = 1'b0;
    repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  // pre: 0 none, 1 garbage prefix ending with 0x07
  task automatic run_pkt(input string tag, input logic [7:0] cmd, input logic [31:0] addr,
                         input int n, input int len_ovr, input bit bad_cs, input int pre);
    logic [7:0] body [0:254];
    logic [7:0] sum;
    int len;
    int w0, t0, r0, i0, k;
    bit all_in, known, good;
    body[0] = cmd;
    for (int i = 0; i < 4; i++) body[1 + i] = addr[31 - 8*i -: 8];
    for (int i = 0; i < n; i++) body[5 + i] = 8'($urandom);
    len = (len_ovr >= 0) ? len_ovr : 5 + n;
    w0 = wn; t0 = tx_n; r0 = run_n; i0 = info_n;
    if (pre == 1) begin
      send_byte(8'h33, 1'b0);
      send_byte(8'h0E, 1'b0);
      send_byte(8'h07, 1'b0);
    end
    send_byte(8'h07, 1'b0);
    send_byte(8'h0E, 1'b0);
    send_byte(8'(len), 1'b0);
    sum = 8'(len);
    for (int i = 0; i < len; i++) begin
      send_byte(body[i], 1'b0);
      sum = sum + body[i];
    end
    send_byte(8'(-sum) + 8'(bad_cs), 1'b0);
    repeat (3) @(negedge clk);

    all_in = 1'b1;
    for (int i = 0; i < n; i++) if (!inw(addr + 32'(i))) all_in = 1'b0;
    known = (cmd == 8'h57) || (cmd == 8'h52) || (cmd == 8'h49);
    good = !bad_cs && (len >= 5) && known;
    if (cmd == 8'h57) good = good && all_in;
    if (cmd == 8'h52) good = good && inw(addr);

    chk(tx_n - t0 == 1, {tag, " R7 reply count"}, 32'(tx_n - t0), 32'd1);
    chk(tx_last == (good ? 8'h06 : 8'h07), {tag, " R7 reply code"}, 32'(tx_last),
        good ? 32'h06 : 32'h07);
    k = w0;
    if (cmd == 8'h57 && len >= 5) begin
      for (int i = 0; i < n; i++) begin
        if (inw(addr + 32'(i))) begin
          chk(wa[k % 512] == addr + 32'(i) && wd[k % 512] == body[5 + i],
              {tag, " R5 write"}, wa[k % 512], addr + 32'(i));
          k++;
        end
      end
    end
    chk(wn == k, {tag, " R6 write count"}, 32'(wn - w0), 32'(k - w0));
    chk(run_n - r0 == int'(good && cmd == 8'h52), {tag, " R8 run pulse"},
        32'(run_n - r0), 32'(good && cmd == 8'h52));
    if (good && cmd == 8'h52)
      chk(run_last == addr, {tag, " R4 run address"}, run_last, addr);
    chk(info_n - i0 == int'(good && cmd == 8'h49), {tag, " R8 info pulse"},
        32'(info_n - i0), 32'(good && cmd == 8'h49));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
    $finish;
  end

  initial begin
    int t0;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_valid && !mem_we && !run_req && !info_req, "R7 reset outputs idle",
        {28'd0, tx_valid, mem_we, run_req, info_req}, 32'd0);

    run_pkt("R1 garbage then 07 07 0E", 8'h57, 32'h2000_0010, 8, -1, 1'b0, 1);
    run_pkt("R9 short length", 8'h57, 32'h2000_0020, 0, 3, 1'b0, 0);
    run_pkt("R9 zero length", 8'h57, 32'h2000_0020, 0, 0, 1'b0, 0);
    run_pkt("R9 unknown cmd", 8'h51, 32'h2000_0030, 4, -1, 1'b0, 0);
    run_pkt("R8 info outside window", 8'h49, 32'h9ABC_DEF0, 0, -1, 1'b0, 0);
    run_pkt("R4 run in window", 8'h52, 32'h2000_0A5C, 0, -1, 1'b0, 0);
    run_pkt("R6 run outside window", 8'h52, 32'h1FFF_FFFF, 0, -1, 1'b0, 0);
    run_pkt("R6 write straddles top", 8'h57, 32'h2000_0FFA, 12, -1, 1'b0, 0);
    run_pkt("R3 bad checksum write", 8'h57, 32'h2000_0100, 6, -1, 1'b1, 0);
    run_pkt("R2 max payload", 8'h57, 32'h2000_0200, 250, -1, 1'b0, 0);

    // R10: error byte mid-packet, then a clean packet
    t0 = tx_n;
    send_byte(8'h07, 1'b0);
    send_byte(8'h0E, 1'b0);
    send_byte(8'h0A, 1'b0);
    send_byte(8'h57, 1'b0);
    send_byte(8'h20, 1'b1);
    repeat (2) @(negedge clk);
    chk(tx_n - t0 == 1 && tx_last == 8'h07, "R10 error byte NAK", 32'(tx_last), 32'h07);
    run_pkt("R10 recovery", 8'h57, 32'h2000_0300, 3, -1, 1'b0, 0);

    for (int it = 0; it < 60; it++) begin
      int sel;
      logic [7:0] c;
      logic [31:0] a;
      int n;
      sel = $urandom_range(0, 9);
      c = (sel < 6) ? 8'h57 : (sel < 8) ? 8'h52 : (sel < 9) ? 8'h49 : 8'h41;
      case ($urandom_range(0, 3))
        0: a = 32'h2000_0000 + 32'($urandom_range(0, 3000));
        1: a = 32'h2000_0F00 + 32'($urandom_range(0, 255));
        2: a = 32'h1FFF_FFF0 + 32'($urandom_range(0, 31));
        default: a = $urandom;
      endcase
      n = (c == 8'h57 || c == 8'h41) ? $urandom_range(0, 40) : 0;
      run_pkt("R5 random", c, a, n, -1, ($urandom_range(0, 5) == 0), 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule